// File: doc/BRIEF.md
# Receive Data and Status FIFO with Overrun Lockout

This block sits between a serial receiver and the register interface that software reads. Each time the receiver finishes a character it strobes the byte in, together with a parity-error, a framing-error and a break indication. The block queues up to four such entries and always presents the oldest one, data and flags, on its head outputs. A pop strobe discards the head and exposes the next entry.

When the receiver completes a character while the queue is full, that character is discarded. Instead of recording the loss against the lost byte, the block marks the most recently stored entry with an overrun flag and refuses every further write. The refusal lasts until that marked entry has become the head, its overrun has reached the sticky error latches, and software has cleared the latches. The receiver can also report an overrun directly through a pulse input, which marks the newest entry in the same way. A break character that arrives while the queue is full is treated as an overrun, and its flags are not stored.

A set of four sticky error latches collects the flags of every entry at the moment it becomes the head. A software strobe clears them. A low receiver-enable empties the queue and clears the latches and the lockout, just as reset does.

Top module: `rx_stat_fifo`

## Requirements
- R1: During and after synchronous active-low reset, avail, full and locked are 0, and head_data, head_flags and err_flags are all zero.
- R2: A write is accepted when the queue is neither full nor locked and ovr_in is low. From the next cycle, avail is high whenever at least one entry is held, and full is high when four are held.
- R3: head_data and head_flags show the oldest entry, with flag bits bit0 = parity error, bit1 = framing error, bit2 = overrun, bit3 = break. Entries leave in write order. When the queue is empty, both outputs read zero.
- R4: A pop removes the head at the next edge. A pop on an empty queue changes nothing.
- R5: A write while the queue is full is dropped, and this includes a break byte. A pop in the same cycle does not make room for it. The newest stored entry gets its overrun bit set, and locked goes high at the next edge.
- R6: A pulse on ovr_in, when not locked, sets the overrun bit of the newest stored entry and sets locked. If that entry is popped in the same cycle, the pulse is lost.
- R7: While locked is high, writes and ovr_in pulses are ignored.
- R8: Each err_flags bit is set when an entry carrying that flag becomes the head, or when the head gets its overrun bit while it is the head. The bits stay set until cleared.
- R9: clr_err clears all err_flags bits at the next edge. A set that occurs in the same cycle takes priority over the clear.
- R10: locked falls only at an edge where clr_err is high while the err_flags overrun bit is already set.
- R11: When rx_en is low at an edge, the queue empties and the latches and the lockout clear, exactly as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes the block |
| wr_en | input | 1 | Receiver has finished a character |
| wr_data | input | 8 | Received byte |
| wr_par_err | input | 1 | Parity error for the received byte |
| wr_frm_err | input | 1 | Framing error for the received byte |
| wr_brk | input | 1 | Received byte is a break |
| ovr_in | input | 1 | Overrun reported directly by the receiver |
| pop | input | 1 | Discard the head entry |
| clr_err | input | 1 | Software clear of the sticky latches |
| avail | output | 1 | At least one entry held |
| full | output | 1 | Four entries held |
| locked | output | 1 | Overrun lockout active |
| head_data | output | 8 | Data byte of the oldest entry |
| head_flags | output | 4 | Flags of the oldest entry |
| err_flags | output | 4 | Sticky error latches, same bit order as head_flags |

## Verification
Every output comes from a register, so any strobe shows up exactly one edge later. This holds for a write, a pop, an overrun, a clear and a flush, and also for the latch set that happens when a new entry reaches the head. The bench drives each stimulus on a falling edge and waits for one rising edge. On the following falling edge it compares every output against a queue model that was updated with the same stimulus. Cases where two events fall in one cycle are driven as single combined steps, so that their one-edge result is checked directly. These include a pop together with an overrun, a pop together with a write into a single-entry queue, and a clear together with a new arrival at the head.

// File: rtl/rxf_pkg.sv
// Shared constants for the receive queue: flag vector layout.
package rxf_pkg;
    localparam int FLAG_W = 4;
    localparam int F_PAR  = 0;
    localparam int F_FRM  = 1;
    localparam int F_OVR  = 2;
    localparam int F_BRK  = 3;
    typedef logic [FLAG_W-1:0] rx_flags_t;
    localparam rx_flags_t OVR_MASK = rx_flags_t'(1) << F_OVR;
endpackage

// File: rtl/rxf_store.sv
// Entry storage: a data array and a flag array indexed by slot.
// One write port and one overrun-tag port; reads the slot at raddr and the
// slot that follows it. Assumes DEPTH is a power of two (pointers wrap).
module rxf_store
    import rxf_pkg::*;
#(
    parameter  int DEPTH  = 4,
    parameter  int DATA_W = 8,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  rx_flags_t         wflags,
    input  logic              tag_en,
    input  logic [PTR_W-1:0]  tag_idx,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata,
    output rx_flags_t         rflags,
    output rx_flags_t         nflags
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    rx_flags_t         mem_f [DEPTH];
    logic [PTR_W-1:0]  raddr_nxt;

    // Data slots: written only on an accepted push.
    always_ff @(posedge clk) begin
        if (we) mem_d[waddr] <= wdata;
    end

    // Flag slots: loaded on push, overrun bit raised by a tag.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                               mem_f[g] <= '0;
            else if (we && waddr == PTR_W'(g))        mem_f[g] <= wflags;
            else if (tag_en && tag_idx == PTR_W'(g))  mem_f[g][F_OVR] <= 1'b1;
        end
    end

    // Read ports: head slot and its successor.
    always_comb begin
        raddr_nxt = raddr + PTR_W'(1);
        rdata     = mem_d[raddr];
        rflags    = mem_f[raddr];
        nflags    = mem_f[raddr_nxt];
    end

    // R6: a tagged slot carries its overrun bit one edge later.
    assert_tag_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tag_en |=> mem_f[$past(tag_idx)][F_OVR]);
endmodule

// File: rtl/rxf_ctrl.sv
// Queue control: pointers, occupancy, overrun detection and lockout.
// Decides which events happen this cycle and tells the top which entry
// becomes the head. Assumes DEPTH is a power of two and at least 2.
module rxf_ctrl #(
    parameter  int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             ovr_in,
    input  logic             pop,
    input  logic             clr_err,
    input  logic             err_ovr,
    output logic             push,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             avail,
    output logic             full,
    output logic             locked,
    output logic             tag_ok,
    output logic [PTR_W-1:0] tag_idx,
    output logic             arrive,
    output logic             nh_from_in,
    output logic             tag_second,
    output logic             tag_head
);
    logic [CNT_W-1:0] count, count_n;
    logic             empty, pop_eff, ovr_evt;

    // Event decode for the current cycle.
    always_comb begin
        empty      = (count == '0);
        full       = (count == CNT_W'(DEPTH));
        avail      = !empty;
        ovr_evt    = !locked && (ovr_in || (wr_en && full));
        push       = wr_en && !locked && !full && !ovr_in;
        pop_eff    = pop && !empty;
        tag_ok     = ovr_evt && !empty && !(pop_eff && count == CNT_W'(1));
        tag_idx    = wr_ptr - PTR_W'(1);
        count_n    = count + CNT_W'(push) - CNT_W'(pop_eff);
        arrive     = (count_n != '0) && (empty || pop_eff);
        nh_from_in = empty || (pop_eff && count == CNT_W'(1));
        tag_second = tag_ok && pop_eff && count == CNT_W'(2);
        tag_head   = tag_ok && !pop_eff && count == CNT_W'(1);
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            count <= count_n;
            if (push)    wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop_eff) rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    // Lockout: set by an overrun tag, released by a clear of a set latch.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)        locked <= 1'b0;
        else if (tag_ok)            locked <= 1'b1;
        else if (clr_err && err_ovr) locked <= 1'b0;
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && empty && !wr_en) |=> (count == '0));
    assert_overrun_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !locked && wr_en && full) |=> locked);
    assert_locked_no_growth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && locked && !pop) |=> (count == $past(count)));
    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && locked && !(clr_err && err_ovr)) |=> locked);
endmodule

// File: rtl/rxf_latch.sv
// Sticky error latches, one per flag bit. Set by a set vector, cleared
// by a software strobe; set wins over clear; flush clears everything.
module rxf_latch
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      clr,
    input  rx_flags_t set_vec,
    output rx_flags_t err_q
);
    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        // One latch bit: clear, then OR in the set.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) err_q[b] <= 1'b0;
            else                 err_q[b] <= (err_q[b] && !clr) || set_vec[b];
        end
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !clr) |=> ((err_q & $past(err_q)) == $past(err_q)));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && clr && set_vec == '0) |=> (err_q == '0));
endmodule

// File: rtl/rx_stat_fifo.sv
// Receive data/status queue with overrun tagging and write lockout.
// Presents the oldest entry; latches entry flags as each reaches the head.
// Assumes DEPTH is a power of two, at least 2; all inputs synchronous.
module rx_stat_fifo
    import rxf_pkg::*;
#(
    parameter  int DEPTH  = 4,
    parameter  int DATA_W = 8,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_par_err,
    input  logic              wr_frm_err,
    input  logic              wr_brk,
    input  logic              ovr_in,
    input  logic              pop,
    input  logic              clr_err,
    output logic              avail,
    output logic              full,
    output logic              locked,
    output logic [DATA_W-1:0] head_data,
    output logic [FLAG_W-1:0] head_flags,
    output logic [FLAG_W-1:0] err_flags
);
    logic              flush, push, tag_ok, arrive, nh_from_in, tag_second, tag_head;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, tag_idx;
    logic [DATA_W-1:0] rdata;
    rx_flags_t         in_flags, rflags, nflags, nh_flags, set_vec, err_q;

    // Incoming flag vector and the latch set vector for this cycle.
    always_comb begin
        flush    = !rx_en;
        in_flags = '0;
        in_flags[F_PAR] = wr_par_err;
        in_flags[F_FRM] = wr_frm_err;
        in_flags[F_BRK] = wr_brk;
        nh_flags = nh_from_in ? in_flags
                              : (nflags | (tag_second ? OVR_MASK : '0));
        set_vec  = (arrive ? nh_flags : '0) | (tag_head ? (rflags | OVR_MASK) : '0);
    end

    rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .ovr_in(ovr_in),
        .pop(pop), .clr_err(clr_err), .err_ovr(err_q[F_OVR]), .push(push),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .avail(avail), .full(full),
        .locked(locked), .tag_ok(tag_ok), .tag_idx(tag_idx), .arrive(arrive),
        .nh_from_in(nh_from_in), .tag_second(tag_second), .tag_head(tag_head)
    );

    rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(push), .waddr(wr_ptr), .wdata(wr_data),
        .wflags(in_flags), .tag_en(tag_ok), .tag_idx(tag_idx), .raddr(rd_ptr),
        .rdata(rdata), .rflags(rflags), .nflags(nflags)
    );

    rxf_latch u_latch (
        .clk(clk), .rst_n(rst_n), .flush(flush), .clr(clr_err),
        .set_vec(set_vec), .err_q(err_q)
    );

    // Head outputs read zero while empty.
    always_comb begin
        head_data  = avail ? rdata  : '0;
        head_flags = avail ? rflags : '0;
        err_flags  = err_q;
    end

    // R3: an empty queue never shows data.
    assert_empty_head_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !avail |-> (head_data == '0 && head_flags == '0));
    // R11: a flush leaves the block empty and unlocked.
    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!avail && !locked && err_flags == '0));
endmodule

// File: tb/rx_stat_fifo_test.sv
module rx_stat_fifo_test;
    localparam int CLK_P = 10;

    typedef struct {
        logic [7:0] d;
        logic [3:0] f;
        int         id;
    } ent_t;

    logic       clk = 1'b0, rst_n = 1'b0, rx_en = 1'b1;
    logic       wr_en = 0, wr_par_err = 0, wr_frm_err = 0, wr_brk = 0;
    logic       ovr_in = 0, pop = 0, clr_err = 0;
    logic [7:0] wr_data = '0;
    logic       avail, full, locked;
    logic [7:0] head_data;
    logic [3:0] head_flags, err_flags;

    int   checks = 0, fails = 0, nid = 0, hid = -1;
    ent_t q[$];
    logic lk_m = 0;
    logic [3:0] em = '0, hf = '0;

    always #(CLK_P/2) clk = ~clk;

    rx_stat_fifo uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_en(wr_en), .wr_data(wr_data),
        .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .wr_brk(wr_brk),
        .ovr_in(ovr_in), .pop(pop), .clr_err(clr_err), .avail(avail), .full(full),
        .locked(locked), .head_data(head_data), .head_flags(head_flags),
        .err_flags(err_flags)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare every output against the scoreboard model.
    task automatic monitor(input string tag);
        logic [7:0] ed;
        logic [3:0] ef;
        ed = (q.size() > 0) ? q[0].d : 8'h00;
        ef = (q.size() > 0) ? q[0].f : 4'h0;
        chk(tag, "avail",      {7'b0, avail},  {7'b0, q.size() > 0});
        chk(tag, "full",       {7'b0, full},   {7'b0, q.size() == 4});
        chk(tag, "locked",     {7'b0, locked}, {7'b0, lk_m});
        chk(tag, "head_data",  head_data,      ed);
        chk(tag, "head_flags", {4'b0, head_flags}, {4'b0, ef});
        chk(tag, "err_flags",  {4'b0, err_flags},  {4'b0, em});
    endtask

    // Driver: apply one cycle of stimulus, update the model, then monitor.
    // wf bits: 0 parity, 1 framing, 3 break.
    task automatic step(input logic wr, input logic [7:0] d, input logic [3:0] wf,
                        input logic ov, input logic pp, input logic cl,
                        input logic en, input string tag);
        int   sz;
        logic oe, psh, popd, tg, old_eo;
        wr_en = wr; wr_data = d; wr_par_err = wf[0]; wr_frm_err = wf[1];
        wr_brk = wf[3]; ovr_in = ov; pop = pp; clr_err = cl; rx_en = en;
        if (!en) begin
            q.delete(); lk_m = 0; em = '0; hid = -1; hf = '0;
        end else begin
            sz     = q.size();
            oe     = !lk_m && (ov || (wr && sz == 4));
            psh    = wr && !lk_m && sz < 4 && !ov;
            popd   = pp && sz > 0;
            old_eo = em[2];
            tg     = oe && sz > 0 && !(popd && sz == 1);
            if (tg) q[sz-1].f[2] = 1'b1;
            if (popd) void'(q.pop_front());
            if (psh) begin
                q.push_back('{d, {wf[3], 1'b0, wf[1], wf[0]}, nid});
                nid++;
            end
            if (cl) em = '0;
            if (q.size() > 0 && (q[0].id != hid || q[0].f != hf)) em |= q[0].f;
            if (q.size() > 0) begin hid = q[0].id; hf = q[0].f; end
            else begin hid = -1; hf = '0; end
            if (tg) lk_m = 1'b1;
            else if (cl && old_eo) lk_m = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        monitor(tag);
    endtask

    task automatic wr(input logic [7:0] d, input logic [3:0] f, input string tag);
        step(1, d, f, 0, 0, 0, 1, tag);
    endtask
    task automatic pp(input string tag);
        step(0, 8'h00, 4'h0, 0, 1, 0, 1, tag);
    endtask
    task automatic cl(input string tag);
        step(0, 8'h00, 4'h0, 0, 0, 1, 1, tag);
    endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        monitor("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        monitor("R1 after reset");

        // R2 R3: basic order, flag layout, empty head zero
        wr(8'hA5, 4'h0, "R2 first write");
        wr(8'h3C, 4'h1, "R2 parity entry");
        pp("R3 R8 parity reaches head");
        pp("R3 drain to empty");
        pp("R4 pop on empty ignored");
        cl("R9 clear latches");

        // R5 R7 R10: overrun while full, lockout and its release
        wr(8'h11, 4'h0, "R2 fill");
        wr(8'h22, 4'h2, "R2 fill framing");
        wr(8'h33, 4'h0, "R2 fill");
        wr(8'h44, 4'h0, "R2 full");
        wr(8'h55, 4'h0, "R5 write while full");
        wr(8'h66, 4'h1, "R7 write while locked");
        step(0, 8'h00, 4'h0, 1, 0, 0, 1, "R7 ovr_in while locked");
        cl("R10 clear before tagged head keeps lock");
        pp("R3 pop");
        pp("R8 framing entry at head");
        pp("R8 tagged entry at head");
        wr(8'h77, 4'h0, "R7 still locked");
        cl("R10 clear releases lock");
        wr(8'h77, 4'h0, "R2 accepted after release");
        pp("R3 pop tagged");
        pp("R4 drain");

        // R5: break while full, pop in same cycle gives no room
        wr(8'h01, 4'h0, "R2 fill");
        wr(8'h02, 4'h0, "R2 fill");
        wr(8'h03, 4'h0, "R2 fill");
        wr(8'h04, 4'h0, "R2 fill");
        step(1, 8'h00, 4'hA, 0, 1, 0, 1, "R5 break while full with pop");
        pp("R3 pop");
        pp("R8 tagged reaches head, no break");

        // R11: flush, then break stored into empty queue
        step(0, 8'h00, 4'h0, 0, 0, 0, 0, "R11 flush");
        wr(8'h00, 4'hA, "R8 break stored into empty");
        cl("R9 clear");

        // R6: overrun pulse tags newest, not head
        wr(8'hB1, 4'h0, "R2 write");
        step(0, 8'h00, 4'h0, 1, 0, 0, 1, "R6 ovr_in tags newest");
        step(0, 8'h00, 4'h0, 0, 1, 1, 1, "R9 R10 clear with arrival of tagged");
        cl("R10 clear releases");
        pp("R4 drain");

        // R6 R8: tag on head, pulse lost on popped single entry, pop+write
        wr(8'hC1, 4'h0, "R2 single entry");
        step(0, 8'h00, 4'h0, 1, 0, 0, 1, "R6 R8 tag on head");
        cl("R10 release");
        step(1, 8'hC2, 4'h2, 0, 1, 0, 1, "R3 pop and write single entry");
        step(0, 8'h00, 4'h0, 1, 1, 0, 1, "R6 pulse lost with pop");
        step(0, 8'h00, 4'h0, 0, 0, 0, 0, "R11 final flush");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule